// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address by reading a two-level page table held in memory. A caller presents an address together with the physical base of the outer directory and the number of directory entries in use. The walker checks the directory index against that count. It then fetches the directory entry and, when that entry points to a second-level table, fetches the leaf entry. It finishes with a one-cycle result strobe that carries either the physical address or a fault code.

Memory is reached through a single-outstanding read port. A request is held with a valid/ready handshake and answered later by a data-valid pulse. A directory entry may instead describe one 4 MB page. In that case the walk stops after a single read and the low 22 address bits pass straight through as the offset. Only one walk is in flight at a time, and a new request is taken only while the walker is idle.

The states are IDLE, DIR_REQ (directory read offered), DIR_WAIT (directory data awaited), LEAF_REQ, LEAF_WAIT and DONE (result strobe). The transitions are as follows:
- IDLE→DIR_REQ on an accepted request whose index is in range.
- IDLE→DONE on an out-of-range index.
- DIR_REQ→DIR_WAIT and LEAF_REQ→LEAF_WAIT on a read handshake.
- DIR_WAIT→DONE on an invalid entry or a large page.
- DIR_WAIT→LEAF_REQ on a valid 4 KB entry.
- LEAF_WAIT→DONE on leaf data.
- DONE→IDLE always.

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready` is 1 and `done_valid` and `mem_rd_valid` are 0.
- R2: The directory entry is read at `tbl_base + 4*vaddr[31:22]`. The leaf entry is read at `{dir[31:12], 12'b0} + 4*vaddr[21:12]`.
- R3: When the directory entry has bit 0 = 1 and bit 7 = 0, and the leaf entry has bit 0 = 1, the result is `{leaf[31:12], vaddr[11:0]}` with fault code 0. Exactly two table reads are made.
- R4: When the directory entry has bit 0 = 1 and bit 7 = 1, the result is `{dir[31:22], vaddr[21:0]}` with fault code 0. Only one read is made, and directory bits 21:12 have no effect.
- R5: A directory entry with bit 0 = 0 ends the walk with fault code 2 and `done_paddr` = 0. No leaf read is made, whatever bit 7 holds.
- R6: A leaf entry with bit 0 = 0 ends the walk with fault code 3 and `done_paddr` = 0.
- R7: When `{1'b0, vaddr[31:22]} >= tbl_len` at acceptance, the result is fault code 1 with `done_paddr` = 0. No memory read is made, and `done_valid` rises in the cycle right after acceptance.
- R8: Bit 7 of a leaf entry has no effect on the result.
- R9: `done_valid` lasts exactly one cycle, and every accepted request yields exactly one strobe. `req_ready` is 1 only while idle, so a request held during a walk or during the strobe cycle is taken only in the following idle cycle.
- R10: While `mem_rd_valid` is 1 and `mem_rd_ready` is 0, the read request and its address stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request |
| req_vaddr | input | 32 | Linear address to translate |
| tbl_base | input | 32 | Physical base of the outer directory, sampled at acceptance |
| tbl_len | input | 11 | Number of valid directory entries (0..1024), sampled at acceptance |
| req_ready | output | 1 | Walker idle, request accepted this cycle if valid |
| mem_rd_valid | output | 1 | Table read request |
| mem_rd_addr | output | 32 | Byte address of the table entry |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | 32 | Table entry returned |
| done_valid | output | 1 | One-cycle result strobe |
| done_paddr | output | 32 | Physical address, 0 on a fault |
| done_fault | output | 2 | 0 none, 1 length, 2 invalid directory entry, 3 invalid leaf entry |

## Verification
The result strobe of one walk and the arrival of the next request can coincide in a single cycle. The bench raises a new request in the very cycle `done_valid` is high and keeps it raised. It then judges three things. First, `req_ready` must be low in that cycle and high in the next. Second, the finishing result must belong to the first address. Third, the second address must produce its own correct translation with exactly one further strobe. Around this, the bench sweeps directory indices across and beyond the length limit, paired with many inner indices and offsets. It compares every result, read count and read address against values computed from a synthetic table, while the memory model varies latency and stalls `mem_rd_ready`.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIR_REQ,
        ST_DIR_WAIT,
        ST_LEAF_REQ,
        ST_LEAF_WAIT,
        ST_DONE
    } walk_state_t;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_LEN  = 2'd1,
        FLT_DIR  = 2'd2,
        FLT_LEAF = 2'd3
    } walk_fault_t;

endpackage

// File: rtl/pt_entry_dec.sv
module pt_entry_dec #(
    parameter int AW      = 32,
    parameter int IDX_W   = 10,
    parameter int OFF_W   = 12,
    parameter int VLD_BIT = 0,
    parameter int PS_BIT  = 7
) (
    input  logic [AW-1:0]                   entry,
    output logic                            ent_valid,
    output logic                            ent_large,
    output logic [AW-OFF_W-1:0]             frame_small,
    output logic [AW-IDX_W-OFF_W-1:0]       frame_large
);
    localparam int LOFF_W = IDX_W + OFF_W;

    always_comb begin
        ent_valid   = entry[VLD_BIT];
        ent_large   = entry[PS_BIT];
        frame_small = entry[AW-1:OFF_W];
        frame_large = entry[AW-1:LOFF_W];
    end
endmodule

// File: rtl/pt_addr_gen.sv
module pt_addr_gen #(
    parameter int AW      = 32,
    parameter int IDX_W   = 10,
    parameter int ESZ_LOG = 2
) (
    input  logic [AW-1:0]    base,
    input  logic [IDX_W-1:0] index,
    output logic [AW-1:0]    addr
);
    localparam int PAD_W = AW - IDX_W - ESZ_LOG;

    always_comb begin
        addr = base + {{PAD_W{1'b0}}, index, {ESZ_LOG{1'b0}}};
    end
endmodule

// File: rtl/pt_walk_fsm.sv
module pt_walk_fsm
    import pt_walker_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        len_ok,
    input  logic        mem_rd_ready,
    input  logic        mem_rsp_valid,
    input  logic        ent_valid,
    input  logic        ent_large,
    output walk_state_t state,
    output logic        req_ready,
    output logic        rd_valid,
    output logic        done_valid,
    output logic        accept,
    output logic        dir_take,
    output logic        leaf_take
);
    walk_state_t state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_d;
        end
    end

    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    state_d = len_ok ? ST_DIR_REQ : ST_DONE;
                end
            end
            ST_DIR_REQ: begin
                if (mem_rd_ready) begin
                    state_d = ST_DIR_WAIT;
                end
            end
            ST_DIR_WAIT: begin
                if (mem_rsp_valid) begin
                    state_d = (!ent_valid || ent_large) ? ST_DONE : ST_LEAF_REQ;
                end
            end
            ST_LEAF_REQ: begin
                if (mem_rd_ready) begin
                    state_d = ST_LEAF_WAIT;
                end
            end
            ST_LEAF_WAIT: begin
                if (mem_rsp_valid) begin
                    state_d = ST_DONE;
                end
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    always_comb begin
        req_ready  = (state == ST_IDLE);
        rd_valid   = (state == ST_DIR_REQ) || (state == ST_LEAF_REQ);
        done_valid = (state == ST_DONE);
        accept     = req_ready && req_valid;
        dir_take   = (state == ST_DIR_WAIT) && mem_rsp_valid;
        leaf_take  = (state == ST_LEAF_WAIT) && mem_rsp_valid;
    end

    AST_LARGE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        dir_take && ent_valid && ent_large |=> done_valid && !rd_valid); // R4

    AST_BAD_DIR_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        dir_take && !ent_valid |=> done_valid && !rd_valid); // R5

    AST_DONE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> req_ready); // R9
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pt_walker_pkg::*;
#(
    parameter int AW      = 32,
    parameter int IDX_W   = 10,
    parameter int OFF_W   = 12,
    parameter int VLD_BIT = 0,
    parameter int PS_BIT  = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [AW-1:0]        req_vaddr,
    input  logic [AW-1:0]        tbl_base,
    input  logic [IDX_W:0]       tbl_len,
    output logic                 req_ready,
    output logic                 mem_rd_valid,
    output logic [AW-1:0]        mem_rd_addr,
    input  logic                 mem_rd_ready,
    input  logic                 mem_rsp_valid,
    input  logic [AW-1:0]        mem_rsp_data,
    output logic                 done_valid,
    output logic [AW-1:0]        done_paddr,
    output logic [1:0]           done_fault
);
    localparam int LOFF_W  = IDX_W + OFF_W;
    localparam int SFR_W   = AW - OFF_W;
    localparam int LFR_W   = AW - LOFF_W;
    localparam int ESZ_LOG = 2;

    walk_state_t       state;
    logic              accept, dir_take, leaf_take, len_ok;
    logic              ent_valid, ent_large;
    logic [SFR_W-1:0]  frame_small;
    logic [LFR_W-1:0]  frame_large;
    logic [AW-1:0]     va_q, base_q, leaf_base_q, paddr_q;
    logic [AW-1:0]     dir_addr, leaf_addr;
    walk_fault_t       fault_q;

    assign len_ok = ({1'b0, req_vaddr[AW-1 -: IDX_W]} < tbl_len);

    pt_walk_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .len_ok       (len_ok),
        .mem_rd_ready (mem_rd_ready),
        .mem_rsp_valid(mem_rsp_valid),
        .ent_valid    (ent_valid),
        .ent_large    (ent_large),
        .state        (state),
        .req_ready    (req_ready),
        .rd_valid     (mem_rd_valid),
        .done_valid   (done_valid),
        .accept       (accept),
        .dir_take     (dir_take),
        .leaf_take    (leaf_take)
    );

    pt_entry_dec #(
        .AW(AW), .IDX_W(IDX_W), .OFF_W(OFF_W), .VLD_BIT(VLD_BIT), .PS_BIT(PS_BIT)
    ) u_dec (
        .entry      (mem_rsp_data),
        .ent_valid  (ent_valid),
        .ent_large  (ent_large),
        .frame_small(frame_small),
        .frame_large(frame_large)
    );

    pt_addr_gen #(.AW(AW), .IDX_W(IDX_W), .ESZ_LOG(ESZ_LOG)) u_dir_addr (
        .base (base_q),
        .index(va_q[AW-1 -: IDX_W]),
        .addr (dir_addr)
    );

    pt_addr_gen #(.AW(AW), .IDX_W(IDX_W), .ESZ_LOG(ESZ_LOG)) u_leaf_addr (
        .base (leaf_base_q),
        .index(va_q[LOFF_W-1:OFF_W]),
        .addr (leaf_addr)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_q        <= '0;
            base_q      <= '0;
            leaf_base_q <= '0;
            paddr_q     <= '0;
            fault_q     <= FLT_NONE;
        end else begin
            if (accept) begin
                va_q    <= req_vaddr;
                base_q  <= tbl_base;
                paddr_q <= '0;
                fault_q <= len_ok ? FLT_NONE : FLT_LEN;
            end
            if (dir_take) begin
                if (!ent_valid) begin
                    fault_q <= FLT_DIR;
                end else if (ent_large) begin
                    paddr_q <= {frame_large, va_q[LOFF_W-1:0]};
                end else begin
                    leaf_base_q <= {frame_small, {OFF_W{1'b0}}};
                end
            end
            if (leaf_take) begin
                if (!ent_valid) begin
                    fault_q <= FLT_LEAF;
                end else begin
                    paddr_q <= {frame_small, va_q[OFF_W-1:0]};
                end
            end
        end
    end

    always_comb begin
        mem_rd_addr = (state == ST_LEAF_REQ) ? leaf_addr : dir_addr;
        done_paddr  = paddr_q;
        done_fault  = fault_q;
    end

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr)); // R10

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !done_valid); // R9

    AST_LEN_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && ({1'b0, req_vaddr[AW-1 -: IDX_W]} >= tbl_len)
        |=> done_valid && done_fault == 2'd1 && !mem_rd_valid); // R7

    AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid && done_fault != 2'd0 |-> done_paddr == '0); // R6

    AST_NO_RD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_rd_valid && !done_valid); // R9
endmodule

// File: tb/pt_walker_tb.sv
module pt_walker_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [31:0] tbl_base = '0;
    logic [10:0] tbl_len = '0;
    logic        req_ready;
    logic        mem_rd_valid;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_ready = 1'b0;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        done_valid;
    logic [31:0] done_paddr;
    logic [1:0]  done_fault;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int ncyc = 0;
    int rd_n = 0;
    int rd_total = 0;
    int done_cnt = 0;
    int issued = 0;
    logic [31:0] rd_log [0:3];
    logic [31:0] cur_base = 32'h0010_0000;
    logic        pend = 1'b0;
    logic [31:0] pend_addr = '0;
    int          lat_cnt = 0;
    logic        prev_done = 1'b0;
    bit          finished = 1'b0;

    always #2.5 clk = ~clk;

    pt_walker u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .tbl_base(tbl_base), .tbl_len(tbl_len), .req_ready(req_ready),
        .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr), .mem_rd_ready(mem_rd_ready),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .done_valid(done_valid), .done_paddr(done_paddr), .done_fault(done_fault)
    );

    function automatic logic [31:0] dir_entry(input logic [9:0] idx);
        logic [9:0] fr;
        logic [9:0] junk;
        fr   = idx * 10'd37 + 10'd5;
        junk = idx ^ 10'h155;
        case (idx % 4)
            3: return 32'h5A5A_5080;
            2: return {fr, junk, 12'h081};
            default: return {20'h08000 + {10'b0, idx}, 12'h001};
        endcase
    endfunction

    function automatic logic [31:0] leaf_entry(input logic [9:0] t, input logic [9:0] j);
        logic [19:0] fr;
        fr = {10'b0, t} * 20'd7 + {10'b0, j} * 20'd13 + 20'h12345;
        if (((int'(t) + int'(j)) % 5) == 4) return 32'h0000_0080;
        return {fr, 4'b0, j[0], 6'b0, 1'b1};
    endfunction

    function automatic logic [31:0] mem_read(input logic [31:0] a);
        logic [31:0] off;
        off = a - cur_base;
        if (a >= cur_base && off < 32'h1000) return dir_entry(off[11:2]);
        if (a[31:22] == 10'h020) return leaf_entry(a[21:12], a[11:2]);
        return 32'hFFFF_FFFE;
    endfunction

    // memory model, driven away from the active edge
    always @(negedge clk) begin
        logic nr;
        ncyc = ncyc + 1;
        if (mem_rsp_valid) mem_rsp_valid = 1'b0;
        if (pend) begin
            if (lat_cnt == 0) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = mem_read(pend_addr);
                pend = 1'b0;
            end else begin
                lat_cnt = lat_cnt - 1;
            end
        end
        nr = !pend && !mem_rsp_valid && ((ncyc % 4) != 1);
        mem_rd_ready = nr;
        if (mem_rd_valid && nr) begin
            pend = 1'b1;
            pend_addr = mem_rd_addr;
            lat_cnt = rd_total % 3;
            if (rd_n < 4) rd_log[rd_n] = mem_rd_addr;
            rd_n = rd_n + 1;
            rd_total = rd_total + 1;
        end
        if (rst_n && done_valid) done_cnt = done_cnt + 1;
        if (rst_n && prev_done && done_valid) begin
            errors = errors + 1;
            $display("FAIL R9 strobe longer than one cycle act=1 exp=0");
        end
        prev_done = done_valid;
    end

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc == 150000 && !finished) begin
            errors = errors + 1;
            $display("FAIL watchdog act=%0d exp=<150000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [31:0] va, input logic [31:0] base, input logic [10:0] len);
        @(negedge clk);
        cur_base  = base;
        req_vaddr = va;
        tbl_base  = base;
        tbl_len   = len;
        req_valid = 1'b1;
        rd_n      = 0;
        issued    = issued + 1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_check(input logic [31:0] va, input logic [31:0] base, input logic [10:0] len);
        int n;
        logic [9:0] o;
        logic [9:0] i;
        logic [31:0] d;
        logic [31:0] l;
        logic [31:0] exp_pa;
        logic [1:0]  exp_f;
        int exp_rd;
        string tag;
        n = 0;
        while (!done_valid && n < 200) begin
            @(negedge clk);
            n = n + 1;
        end
        o = va[31:22];
        i = va[21:12];
        d = dir_entry(o);
        l = leaf_entry(o, i);
        if ({1'b0, o} >= len) begin
            exp_f = 2'd1; exp_pa = '0; exp_rd = 0; tag = "R7";
        end else if (!d[0]) begin
            exp_f = 2'd2; exp_pa = '0; exp_rd = 1; tag = "R5";
        end else if (d[7]) begin
            exp_f = 2'd0; exp_pa = {d[31:22], va[21:0]}; exp_rd = 1; tag = "R4";
        end else if (!l[0]) begin
            exp_f = 2'd3; exp_pa = '0; exp_rd = 2; tag = "R6";
        end else begin
            exp_f = 2'd0; exp_pa = {l[31:12], va[11:0]}; exp_rd = 2;
            tag = l[7] ? "R3/R8" : "R3";
        end
        chk(done_valid, {tag, " done strobe"}, {31'b0, done_valid}, 32'd1);
        chk(done_fault == exp_f, {tag, " fault code"}, {30'b0, done_fault}, {30'b0, exp_f});
        chk(done_paddr == exp_pa, {tag, " paddr"}, done_paddr, exp_pa);
        chk(rd_n == exp_rd, {tag, " read count"}, rd_n, exp_rd);
        if (exp_rd >= 1)
            chk(rd_log[0] == base + {20'b0, o, 2'b00}, "R2 dir addr", rd_log[0], base + {20'b0, o, 2'b00});
        if (exp_rd == 2)
            chk(rd_log[1] == 32'h0800_0000 + {10'b0, o, 12'b0} + {20'b0, i, 2'b00}, "R2 leaf addr",
                rd_log[1], 32'h0800_0000 + {10'b0, o, 12'b0} + {20'b0, i, 2'b00});
        if (exp_f == 2'd1)
            chk(n == 0, "R7 strobe right after accept", n, 0);
    endtask

    task automatic run(input logic [31:0] va, input logic [31:0] base, input logic [10:0] len);
        issue(va, base, len);
        wait_check(va, base, len);
    endtask

    initial begin
        logic [31:0] vb;
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready in reset", {31'b0, req_ready}, 32'd1);
        chk(done_valid == 1'b0, "R1 no strobe", {31'b0, done_valid}, 32'd0);
        chk(mem_rd_valid == 1'b0, "R1 no read", {31'b0, mem_rd_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && done_valid == 1'b0, "R1 after reset", {31'b0, req_ready}, 32'd1);

        // sweep across and beyond the length limit
        for (int o = 0; o < 64; o++) begin
            for (int k = 0; k < 4; k++) begin
                int ii;
                int ff;
                ii = (o * 17 + k * 331) % 1024;
                ff = (o * 29 + k * 1237) % 4096;
                run({o[9:0], ii[9:0], ff[11:0]}, 32'h0010_0000, 11'd48);
            end
        end

        // length boundaries
        run({10'd0, 10'd3, 12'h123}, 32'h0010_0000, 11'd0);   // R7 empty table
        run({10'd5, 10'd3, 12'h123}, 32'h0010_0000, 11'd0);   // R7
        run({10'd0, 10'd2, 12'hABC}, 32'h0010_0000, 11'd1);   // R3 last in-range index
        run({10'd1, 10'd2, 12'hABC}, 32'h0010_0000, 11'd1);   // R7 first out-of-range
        run({10'd1021, 10'd700, 12'h5A5}, 32'h0030_0000, 11'd1024); // R2 top of table
        run({10'd1022, 10'd700, 12'h5A5}, 32'h0030_0000, 11'd1024); // R4
        run({10'd1023, 10'd700, 12'h5A5}, 32'h0030_0000, 11'd1024); // R5

        // R9: new request raised in the strobe cycle
        issue({10'd4, 10'd9, 12'h321}, 32'h0010_0000, 11'd64);
        wait_check({10'd4, 10'd9, 12'h321}, 32'h0010_0000, 11'd64);
        vb = {10'd8, 10'd11, 12'h777};
        req_vaddr = vb;
        req_valid = 1'b1;
        rd_n = 0;
        issued = issued + 1;
        chk(req_ready == 1'b0, "R9 not ready during strobe", {31'b0, req_ready}, 32'd0);
        @(negedge clk);
        chk(req_ready == 1'b1 && done_valid == 1'b0, "R9 ready after strobe", {31'b0, req_ready}, 32'd1);
        @(negedge clk);
        req_valid = 1'b0;
        wait_check(vb, 32'h0010_0000, 11'd64);

        repeat (4) @(negedge clk);
        chk(done_cnt == issued, "R9 one strobe per request", done_cnt, issued);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule